// File: doc/BRIEF.md
# DRAM power-up initialization sequencer

This block brings a two-bank synchronous graphics DRAM from reset to a usable state. While reset is high it takes a snapshot of three settings: the requested wait length in clock cycles, the mode-register value, and the order of the final two steps. After reset is released it drives a fixed command sequence onto the memory's command and address pins. The sequence is a long idle pause, one precharge of both banks, a run of auto-refresh commands, and one mode-register write. When the sequence is complete it raises `init_done`, which the normal memory controller uses as its go signal.

The pause is never shorter than the required power-up settling time. That floor is `CLK_MHZ * WAIT_US` cycles. A smaller requested count is raised to the floor, and a larger one is used as given. Throughout the sequence, CKE and the DQM mask stay high and chip select stays low. The DSF pin stays low, so a cycle with all three strobes high reads as a NOP.

The controller has eight states:
- `ST_WAIT`: the pause.
- `ST_PRE`: the precharge-all command.
- `ST_PRE_GAP`: idle cycles after the precharge.
- `ST_REF`: one refresh command.
- `ST_REF_GAP`: idle cycles after each refresh.
- `ST_MRS`: the mode-register write.
- `ST_MRS_GAP`: one idle cycle, used only when the mode write comes first.
- `ST_DONE`: the sequence is complete.

Its transitions are as follows:
- WAIT→PRE when the pause count is reached.
- PRE→PRE_GAP always.
- PRE_GAP→REF, or PRE_GAP→MRS when the mode write comes first, after `TRP_GAP` cycles.
- REF→REF_GAP always.
- REF_GAP→REF after `TRFC_GAP` cycles while refreshes remain.
- REF_GAP→MRS (normal order) or REF_GAP→DONE (swapped order) after the last refresh.
- MRS→DONE (normal order) or MRS→MRS_GAP (swapped order).
- MRS_GAP→REF.
- Any state returns to WAIT on reset.

Top module: `dram_init_seq`

## Requirements
- R1: From reset through the whole pause, `cke` and `dqm` are 1, `cs_n` is 0, `dsf` is 0, `ras_n`/`cas_n`/`we_n` are 1 (NOP), `addr` is 0 and `init_done` is 0. `cs_n` and `dsf` stay 0 and `cke`/`dqm` stay 1 on every cycle.
- R2: The pause lasts exactly max(`wait_cycles`, `CLK_MHZ*WAIT_US`) cycles, counted from the first cycle after reset is released.
- R3: The cycle right after the pause carries a precharge-all: `ras_n`=0, `cas_n`=1, `we_n`=0, and `addr` has only bit `PALL_BIT` (8) set. It is followed by `TRP_GAP` NOP cycles.
- R4: Exactly `NUM_REF` (at least 2) auto-refresh commands are issued: `ras_n`=0, `cas_n`=0, `we_n`=1, `addr`=0. Each is followed by `TRFC_GAP` NOP cycles.
- R5: The mode write drives `ras_n`, `cas_n`, `we_n` and `dsf` all to 0, with `addr` equal to the captured `mode_val`. This carries the burst-length field from bits [2:0] onto A0–A2 unchanged.
- R6: With `mrs_first`=0, the refreshes come right after the precharge gap and the mode write follows the last refresh gap. With `mrs_first`=1, the mode write comes right after the precharge gap, then one NOP, then the refreshes.
- R7: `init_done` rises one cycle after the mode write when `mrs_first`=0, and one cycle after the last refresh gap when `mrs_first`=1. It then stays high with NOP on the pins.
- R8: `wait_cycles`, `mode_val` and `mrs_first` are sampled only while `rst` is high. Changes after reset is released have no effect on the sequence.
- R9: A synchronous reset in any state returns the block to the start of the pause with `init_done` low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; also the configuration capture window |
| wait_cycles | input | CNT_W | Requested pause length in cycles |
| mode_val | input | ADDR_W | Value written to the mode register |
| mrs_first | input | 1 | 1 = mode write before the refreshes |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| dsf | output | 1 | Special-function pin, held low |
| addr | output | ADDR_W | Address pins A0 upward, including the bank-select bit |
| cke | output | 1 | Clock enable to the memory |
| dqm | output | 1 | Data mask |
| init_done | output | 1 | Sequence complete |

## Verification
The bench attacks the wait clamp from both sides. A zero request, a request exactly at the floor, and requests just below and above the floor would expose a design that used the raw count, since the precharge would land early or late by the difference. Both step orders run with random mode values: a swapped-order bug shows up as a refresh where the mode write should be, or as `init_done` rising one cycle off. The bench toggles the configuration inputs right after reset release, which catches a design that samples them live. It also resets in the middle of a refresh run and again after completion, which catches a sequencer that resumes mid-sequence or leaves `init_done` high.

// File: rtl/dram_init_pkg.sv
`timescale 1ns/1ps
package dram_init_pkg;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_PRE,
        ST_PRE_GAP,
        ST_REF,
        ST_REF_GAP,
        ST_MRS,
        ST_MRS_GAP,
        ST_DONE
    } init_state_t;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_t;

    localparam strobe_t STB_NOP = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam strobe_t STB_PRE = '{ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam strobe_t STB_REF = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam strobe_t STB_MRS = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

endpackage

// File: rtl/dram_init_cfg.sv
`timescale 1ns/1ps
module dram_init_cfg #(
    parameter int CNT_W    = 16,
    parameter int ADDR_W   = 11,
    parameter int MIN_WAIT = 20000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  wait_cycles,
    input  logic [ADDR_W-1:0] mode_val,
    input  logic              mrs_first,
    output logic [CNT_W-1:0]  wait_lim,
    output logic [ADDR_W-1:0] mode_q,
    output logic              first_q
);
    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_WAIT);

    logic [CNT_W-1:0] wait_q;

    // Settings are sampled only inside the reset window.
    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q  <= wait_cycles;
            mode_q  <= mode_val;
            first_q <= mrs_first;
        end
    end

    always_comb begin
        wait_lim = (wait_q < FLOOR) ? FLOOR : wait_q;
    end

    // R2
    wait_floor_chk: assert property (@(posedge clk) disable iff (rst)
        wait_lim >= FLOOR);

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(mode_q) && $stable(first_q) && $stable(wait_q));
endmodule

// File: rtl/dram_init_timer.sv
`timescale 1ns/1ps
module dram_init_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dram_init_fsm.sv
`timescale 1ns/1ps
module dram_init_fsm
    import dram_init_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int NUM_REF  = 2,
    parameter int TRP_GAP  = 2,
    parameter int TRFC_GAP = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] wait_lim,
    input  logic             first_q,
    input  logic [CNT_W-1:0] cnt,
    output init_state_t      state,
    output logic             clr,
    output logic             en
);
    localparam int REF_W = $clog2(NUM_REF + 1);
    localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(TRP_GAP - 1);
    localparam logic [CNT_W-1:0] REF_LAST  = CNT_W'(TRFC_GAP - 1);
    localparam logic [REF_W-1:0] REF_TOTAL = REF_W'(NUM_REF);

    init_state_t      state_nx;
    logic [REF_W-1:0] ref_cnt;
    logic             refs_done;

    assign refs_done = (ref_cnt == REF_TOTAL);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WAIT:    if (cnt == wait_lim - 1'b1) state_nx = ST_PRE;
            ST_PRE:     state_nx = ST_PRE_GAP;
            ST_PRE_GAP: if (cnt == PRE_LAST) state_nx = first_q ? ST_MRS : ST_REF;
            ST_REF:     state_nx = ST_REF_GAP;
            ST_REF_GAP: if (cnt == REF_LAST) begin
                            if (!refs_done)   state_nx = ST_REF;
                            else if (first_q) state_nx = ST_DONE;
                            else              state_nx = ST_MRS;
                        end
            ST_MRS:     state_nx = first_q ? ST_MRS_GAP : ST_DONE;
            ST_MRS_GAP: state_nx = ST_REF;
            ST_DONE:    state_nx = ST_DONE;
            default:    state_nx = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_WAIT;
            ref_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_REF) ref_cnt <= ref_cnt + 1'b1;
        end
    end

    assign clr = (state_nx != state);
    assign en  = (state != ST_DONE);

    // R3
    pre_after_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PRE) |-> ($past(state) == ST_WAIT));

    // R4
    ref_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ref_cnt <= REF_TOTAL);

    // R6
    mrs_order_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MRS) |-> (ref_cnt == (first_q ? '0 : REF_TOTAL)));

    // R4
    done_refs_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE) |-> refs_done);
endmodule

// File: rtl/dram_init_seq.sv
`timescale 1ns/1ps
module dram_init_seq
    import dram_init_pkg::*;
#(
    parameter int CLK_MHZ  = 100,
    parameter int WAIT_US  = 200,
    parameter int NUM_REF  = 2,
    parameter int TRP_GAP  = 2,
    parameter int TRFC_GAP = 7,
    parameter int CNT_W    = 16,
    parameter int ADDR_W   = 11,
    parameter int PALL_BIT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  wait_cycles,
    input  logic [ADDR_W-1:0] mode_val,
    input  logic              mrs_first,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              dsf,
    output logic [ADDR_W-1:0] addr,
    output logic              cke,
    output logic              dqm,
    output logic              init_done
);
    localparam int MIN_WAIT = CLK_MHZ * WAIT_US;
    localparam logic [ADDR_W-1:0] PALL_ADDR = ADDR_W'(1) << PALL_BIT;

    logic [CNT_W-1:0]  wait_lim;
    logic [ADDR_W-1:0] mode_q;
    logic              first_q;
    logic [CNT_W-1:0]  cnt;
    logic              clr;
    logic              en;
    init_state_t       state;
    strobe_t           stb;

    dram_init_cfg #(
        .CNT_W    (CNT_W),
        .ADDR_W   (ADDR_W),
        .MIN_WAIT (MIN_WAIT)
    ) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .wait_cycles (wait_cycles),
        .mode_val    (mode_val),
        .mrs_first   (mrs_first),
        .wait_lim    (wait_lim),
        .mode_q      (mode_q),
        .first_q     (first_q)
    );

    dram_init_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk (clk),
        .rst (rst),
        .clr (clr),
        .en  (en),
        .cnt (cnt)
    );

    dram_init_fsm #(
        .CNT_W    (CNT_W),
        .NUM_REF  (NUM_REF),
        .TRP_GAP  (TRP_GAP),
        .TRFC_GAP (TRFC_GAP)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .wait_lim (wait_lim),
        .first_q  (first_q),
        .cnt      (cnt),
        .state    (state),
        .clr      (clr),
        .en       (en)
    );

    // Pin decode: Moore outputs from the sequencer state.
    always_comb begin
        stb       = STB_NOP;
        addr      = '0;
        init_done = 1'b0;
        unique case (state)
            ST_PRE:  begin stb = STB_PRE; addr = PALL_ADDR; end
            ST_REF:  stb = STB_REF;
            ST_MRS:  begin stb = STB_MRS; addr = mode_q; end
            ST_DONE: init_done = 1'b1;
            ST_WAIT, ST_PRE_GAP, ST_REF_GAP, ST_MRS_GAP: stb = STB_NOP;
            default: stb = STB_NOP;
        endcase
    end

    assign cs_n  = 1'b0;
    assign dsf   = 1'b0;
    assign cke   = 1'b1;
    assign dqm   = 1'b1;
    assign ras_n = stb.ras_n;
    assign cas_n = stb.cas_n;
    assign we_n  = stb.we_n;

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    // R7
    done_after_mrs_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(init_done) && !first_q) |-> $past(!ras_n && !cas_n && !we_n));

    // R9
    reset_restart_chk: assert property (@(posedge clk)
        $past(rst) |-> (!init_done && ras_n && cas_n && we_n));
endmodule

// File: tb/test_dram_init_seq.sv
`timescale 1ns/1ps
module test_dram_init_seq;
    localparam int CLK_MHZ  = 4;
    localparam int WAIT_US  = 200;
    localparam int NUM_REF  = 3;
    localparam int TRP_GAP  = 2;
    localparam int TRFC_GAP = 3;
    localparam int CNT_W    = 16;
    localparam int ADDR_W   = 11;
    localparam int PALL_BIT = 8;
    localparam int MIN_WAIT = CLK_MHZ * WAIT_US;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [CNT_W-1:0]  wait_cycles = '0;
    logic [ADDR_W-1:0] mode_val = '0;
    logic              mrs_first = 1'b0;
    logic              cs_n, ras_n, cas_n, we_n, dsf, cke, dqm, init_done;
    logic [ADDR_W-1:0] addr;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dram_init_seq #(
        .CLK_MHZ (CLK_MHZ), .WAIT_US (WAIT_US), .NUM_REF (NUM_REF),
        .TRP_GAP (TRP_GAP), .TRFC_GAP (TRFC_GAP), .CNT_W (CNT_W),
        .ADDR_W (ADDR_W), .PALL_BIT (PALL_BIT)
    ) i_dram_init_seq (
        .clk (clk), .rst (rst), .wait_cycles (wait_cycles), .mode_val (mode_val),
        .mrs_first (mrs_first), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n),
        .we_n (we_n), .dsf (dsf), .addr (addr), .cke (cke), .dqm (dqm),
        .init_done (init_done)
    );

    function automatic int eff_wait(int req);
        return (req < MIN_WAIT) ? MIN_WAIT : req;
    endfunction

    // Cycle where the last step ends: MRS cycle (order 0) or done cycle (order 1).
    function automatic int end_cycle(int w, bit first);
        int base = w + TRP_GAP + 1;
        return first ? base + 2 + NUM_REF * (TRFC_GAP + 1)
                     : base + NUM_REF * (TRFC_GAP + 1);
    endfunction

    // 0 NOP, 1 precharge, 2 refresh, 3 mode write
    function automatic int exp_code(int k, int w, bit first);
        int base = w + TRP_GAP + 1;
        int rbase = first ? base + 2 : base;
        if (k == w) return 1;
        if (k < base) return 0;
        if (first && k == base) return 3;
        if (!first && k == end_cycle(w, first)) return 3;
        for (int i = 0; i < NUM_REF; i++)
            if (k == rbase + i * (TRFC_GAP + 1)) return 2;
        return 0;
    endfunction

    function automatic bit exp_done(int k, int w, bit first);
        return first ? (k >= end_cycle(w, first)) : (k > end_cycle(w, first));
    endfunction

    task automatic check_cycle(int k, int w, bit first, logic [ADDR_W-1:0] mode);
        int code = exp_code(k, w, first);
        bit dn = exp_done(k, w, first);
        logic [2:0] stb;
        logic [ADDR_W-1:0] ea;
        string tag;
        logic [ADDR_W+7:0] got, exp;
        case (code)
            1: begin stb = 3'b010; ea = ADDR_W'(1) << PALL_BIT; tag = "R3"; end
            2: begin stb = 3'b001; ea = '0; tag = "R4"; end
            3: begin stb = 3'b000; ea = mode; tag = "R5/R6"; end
            default: begin stb = 3'b111; ea = '0;
                       tag = (k < w) ? "R1/R2" : (dn ? "R7" : "R6"); end
        endcase
        got = {cs_n, ras_n, cas_n, we_n, dsf, cke, dqm, init_done, addr};
        exp = {1'b0, stb, 1'b0, 1'b1, 1'b1, dn, ea};
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d wait %0d order %0d: got %h expected %h",
                     tag, k, w, first, got, exp);
        end
    endtask

    // Full or partial run; stop_at < 0 runs to completion.
    task automatic run_seq(int req, logic [ADDR_W-1:0] mode, bit first,
                           bit perturb, int stop_at);
        int w = eff_wait(req);
        int last = end_cycle(w, first) + 4;
        @(negedge clk);
        rst = 1'b1;
        wait_cycles = CNT_W'(req);
        mode_val = mode;
        mrs_first = first;
        @(negedge clk);
        // R9: one reset edge clears done and restores NOP
        n_chk++;
        if (init_done !== 1'b0 || {ras_n, cas_n, we_n} !== 3'b111) begin
            n_fail++;
            $display("FAIL R9 reset state: got done %b stb %b expected done 0 stb 111",
                     init_done, {ras_n, cas_n, we_n});
        end
        @(negedge clk);
        rst = 1'b0;
        #1;
        for (int k = 0; k <= last; k++) begin
            if (stop_at >= 0 && k == stop_at) return;
            check_cycle(k, w, first, mode);
            if (perturb && k == 3) begin
                // R8: these changes must be ignored
                wait_cycles = CNT_W'(req + 500);
                mode_val = ~mode;
                mrs_first = ~first;
            end
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        // R2: clamp from below, exact floor, above floor
        run_seq(0, 11'h023, 1'b0, 1'b0, -1);
        run_seq(MIN_WAIT, 11'h4a5, 1'b1, 1'b0, -1);
        run_seq(MIN_WAIT - 1, 11'h007, 1'b0, 1'b0, -1);
        run_seq(MIN_WAIT + 37, 11'h532, 1'b1, 1'b0, -1);
        // R8: inputs toggled after release
        run_seq(MIN_WAIT + 11, 11'h2c6, 1'b0, 1'b1, -1);
        run_seq(MIN_WAIT + 5, 11'h13b, 1'b1, 1'b1, -1);
        // R9: reset in the middle of the refresh run
        run_seq(MIN_WAIT, 11'h155, 1'b0, 1'b0, MIN_WAIT + TRP_GAP + 6);
        run_seq(MIN_WAIT + 3, 11'h2aa, 1'b1, 1'b0, -1);
        // random mix
        for (int i = 0; i < 6; i++) begin
            int rq = MIN_WAIT - 100 + int'($urandom_range(0, 300));
            run_seq(rq, ADDR_W'($urandom), 1'($urandom), 1'($urandom), -1);
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule